// File: doc/BRIEF.md
# Shaped Volume Envelope Generator

This block produces a 4-bit volume level that sweeps between 0 and 15 under control of a 4-bit shape code. Any sound channel set to take its loudness from the envelope uses this level. A 16-bit step period sets how fast the level moves. Each step takes that many pulses of an input tick, which already runs at one sixteenth of the chip clock. A period of zero behaves the same as a period of one.

The shape code holds four control bits:

| Bit | Name | Meaning |
|-----|------|---------|
| 2 | attack | starting direction |
| 1 | alternate | direction reversal |
| 0 | hold | stop after the first sweep |
| 3 | continue | clear means the envelope stops after one sweep and sits at 0 |

A sweep always covers the full range in 16 steps. Writing a new shape through the strobe restarts the envelope from the start of its first sweep.

Top module: `env_shaper`

## Requirements
- R1: After reset, `level` is 0 and stays at 0 until a shape is written.
- R2: A step happens on the `period`-th `tick` pulse after the previous step or restart. A `period` of 0 steps on every tick, the same as a period of 1.
- R3: After a strobe in `shape_wr`, `level` is 0 if shape bit 2 is 1, and 15 if bit 2 is 0. The strobe also clears the tick count, so the first step needs a full period.
- R4: Each step moves `level` by one toward the sweep's end. A sweep is 16 levels, 0 to 15 or 15 to 0. Shapes 8 and 12 (continue=1, alternate=0, hold=0) start each new sweep from the same start value.
- R5: When continue is 1, hold is 0 and alternate (bit 1) is 1 (shapes 10 and 14), the direction reverses at the end of every sweep. This gives a triangle.
- R6: When continue is 1 and hold is 1 (shapes 9, 11, 13, 15), the level stops after the first sweep. The final value is 15 when bit 2 differs from bit 1, and 0 when they are equal.
- R7: When continue (bit 3) is 0 (shapes 0 to 7), the level runs one sweep in the attack direction and then stays at 0.
- R8: If a strobe and a tick arrive in the same cycle, the strobe wins and the tick does not count.
- R9: Once the level has stopped, it stays unchanged under any ticks and any period until the next strobe.
- R10: In cycles without `tick` or `shape_wr`, `level` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Enable pulse at one sixteenth of the clock rate |
| period | input | 16 | Step period in ticks (0 acts as 1) |
| shape | input | 4 | Shape code: bit3 continue, bit2 attack, bit1 alternate, bit0 hold |
| shape_wr | input | 1 | One-cycle strobe that loads `shape` and restarts |
| level | output | 4 | Current envelope level |

## Verification
The assertions assume that `shape_wr` is a single-cycle pulse whose `shape` value is valid in that cycle. They also assume that `tick` is a clean one-cycle enable, and that `period` may change at any time. The stimulus drives all inputs on the falling edge. It gives every strobe and tick exactly one rising edge, and it changes `period` only between ticks, including while the level is stopped. A bench model gives the expected level for each shape and step count, and the output is sampled half a cycle after each edge.

// File: rtl/env_shaper.sv
module env_shaper #(
  parameter int PER_W = 16,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [PER_W-1:0] period,
  input  logic [3:0]       shape,
  input  logic             shape_wr,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] LVL_TOP = {LVL_W{1'b1}};

  logic [PER_W-1:0] cnt;
  logic [LVL_W-1:0] pos;
  logic [3:0]       shp;
  logic             up, held, hold_hi;

  wire [PER_W-1:0] per_m1 = (period == '0) ? '0 : period - PER_W'(1);
  wire             last   = (cnt >= per_m1);

  assign level = held ? {LVL_W{hold_hi}} : (up ? pos : ~pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; pos <= '0; shp <= '0;
      up <= 1'b0; held <= 1'b1; hold_hi <= 1'b0;
    end else if (shape_wr) begin
      shp <= shape; cnt <= '0; pos <= '0;
      up <= shape[2]; held <= 1'b0;
    end else if (tick && !held) begin
      if (last) begin
        cnt <= '0;
        if (pos == LVL_TOP) begin
          if (!shp[3] || shp[0]) begin
            held    <= 1'b1;
            hold_hi <= shp[3] & (shp[2] ^ shp[1]);
          end else begin
            pos <= '0;
            up  <= up ^ shp[1];
          end
        end else begin
          pos <= pos + 1'b1;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !shape_wr) |=> $stable(level));

  p_held_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !shape_wr) |=> $stable(level));

  p_restart_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shape_wr |=> (level == ($past(shape[2]) ? '0 : LVL_TOP)));

  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!shape_wr && !held && pos != LVL_TOP) |=>
      (level == $past(level) || level == $past(level) + 1'b1 ||
       level == $past(level) - 1'b1));

  p_quiet_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !shp[3]) |-> (level == '0));
endmodule

// File: tb/env_shaper_test.sv
module env_shaper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] period = 16'd1;
  logic [3:0]  shape = 4'd0;
  logic        shape_wr = 1'b0;
  logic [3:0]  level;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  env_shaper uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .period(period),
    .shape(shape), .shape_wr(shape_wr), .level(level)
  );

  always #4 clk = ~clk;

  function automatic logic [3:0] model(input logic [3:0] s, input int k);
    int sweep = k / 16;
    int p = k % 16;
    logic rising;
    if (sweep >= 1 && (!s[3] || s[0]))
      return (s[3] && (s[2] ^ s[1])) ? 4'd15 : 4'd0;
    rising = s[2] ^ (s[1] & sweep[0]);
    return rising ? 4'(p) : 4'(15 - p);
  endfunction

  task automatic check(input string req, input logic [3:0] exp);
    checks++;
    if (level !== exp) begin
      errors++;
      $display("FAIL %s level=%0d expected=%0d", req, level, exp);
    end
  endtask

  task automatic pulse_tick;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic write_shape(input logic [3:0] s);
    shape = s; shape_wr = 1'b1;
    @(negedge clk);
    shape_wr = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", 4'd0);
    repeat (5) pulse_tick();
    check("R1", 4'd0);
  endtask

  task automatic t_all_shapes;
    for (int s = 0; s < 16; s++) begin
      string tag;
      logic [3:0] sv = 4'(s);
      if (!sv[3]) tag = "R7";
      else if (sv[0]) tag = "R6";
      else if (sv[1]) tag = "R5";
      else tag = "R4";
      period = 16'd1;
      write_shape(sv);
      check("R3", model(sv, 0));
      for (int k = 1; k <= 40; k++) begin
        pulse_tick();
        check(tag, model(sv, k));
      end
    end
  endtask

  task automatic t_period;
    period = 16'd3;
    write_shape(4'hC);
    pulse_tick(); check("R2", 4'd0);
    pulse_tick(); check("R2", 4'd0);
    pulse_tick(); check("R2", 4'd1);
    period = 16'd0;
    pulse_tick(); check("R2", 4'd2);
    pulse_tick(); check("R2", 4'd3);
    period = 16'd2;
    repeat (6) @(negedge clk);
    check("R10", 4'd3);
    pulse_tick(); check("R2", 4'd3);
    repeat (3) @(negedge clk);
    pulse_tick(); check("R10", 4'd4);
  endtask

  task automatic t_priority;
    period = 16'd2;
    write_shape(4'hC);
    pulse_tick();
    check("R8", 4'd0);
    tick = 1'b1; shape = 4'hC; shape_wr = 1'b1;
    @(negedge clk);
    tick = 1'b0; shape_wr = 1'b0;
    check("R8", 4'd0);
    pulse_tick(); check("R3", 4'd0);
    pulse_tick(); check("R3", 4'd1);
  endtask

  task automatic t_held;
    period = 16'd1;
    write_shape(4'hD);
    repeat (16) pulse_tick();
    check("R6", 4'd15);
    period = 16'd0;
    repeat (20) pulse_tick();
    check("R9", 4'd15);
    period = 16'd7;
    repeat (9) pulse_tick();
    check("R9", 4'd15);
    period = 16'd1;
    write_shape(4'h8);
    check("R3", 4'd15);
    pulse_tick(); check("R4", 4'd14);
    repeat (5) pulse_tick();
    write_shape(4'hE);
    check("R3", 4'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_shapes();
    t_period();
    t_priority();
    t_held();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog level=%0d expected=finish", level);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule